// File: doc/BRIEF.md
# Banked RAM power-mode controller

This block holds the power state of a set of on-chip RAM banks, 4096 words each, in a single software-visible control register. Each bank owns two bits of that register: a supply-enable bit and a ground-switch-enable bit. The two bits together select active, retention or disabled operation. The block drives the two bits straight out to the power switches of each bank. It also keeps a per-bank ready flag, which stays low for a fixed settling window after a bank returns to active.

A second register reports status for each bank: a sticky access-error bit and a contents-valid bit. Every CPU or DMA request passes through the block. The upper address bits select the bank. A request to a ready bank is forwarded in the same cycle. A request to any other bank is blocked and produces a violation pulse. When a bank is disabled, or is touched while in retention, its contents are marked lost until software declares them valid again.

Top module: `ram_pwr_ctl`

## Requirements
- R1: After reset, every control bit reads 1, every bank is ready, every contents-valid bit is 1 and every error bit is 0.
- R2: Bank N uses control-register bit 2N+1 as its supply enable and bit 2N as its ground-switch enable. `vdd_en[N]` and `vss_en[N]` always equal those two bits.
- R3: Code 11 means active, 10 means retention, 00 means disabled, and the unused code 01 behaves as disabled. Only an active bank can be ready.
- R4: A write that moves a bank into active from any other code keeps `bank_rdy` low for the next WAKE_CYC (10) cycles. `bank_rdy` rises after the tenth clock edge that follows the write edge. Writing 11 again to a bank that is already active does not restart this window.
- R5: The target bank of a request is `acc_addr[ADDR_W-1:BANK_AW]`, the address bits above the 4096-word offset.
- R6: In the same cycle as the request, a request to a ready bank raises `acc_gnt`, and a request to a bank that is not ready raises `acc_viol` instead. With no request, both outputs are low.
- R7: A violation sets the error bit of the target bank at the next edge. The bit stays set until software writes 1 to status bit N. If a violation and a clear write arrive in the same cycle, the bit stays set.
- R8: The contents-valid bit of a bank clears when the bank enters code 00 or 01 from code 11 or 10.
- R9: A blocked request to a bank in retention clears that bank's contents-valid bit. A request blocked during the wake-up window leaves the bit unchanged.
- R10: Writing 1 to status bit NBANK+N sets contents-valid for bank N. Writing 0 to any status bit has no effect. If a set and a clearing event arrive in the same cycle, the clearing event wins.
- R11: `reg_rdata` shows the control register when `reg_sel` is 0. When `reg_sel` is 1, it shows the status register: valid bits in the upper half and error bits in the lower half.
- R12: A mode change or an access to one bank leaves the ready, valid and error state of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the status register |
| reg_wdata | input | 2*NBANK | Register write data |
| reg_rdata | output | 2*NBANK | Register read data |
| acc_req | input | 1 | Memory access request |
| acc_addr | input | BANK_AW+log2(NBANK) | Word address of the request |
| acc_gnt | output | 1 | Request forwarded to the bank |
| acc_viol | output | 1 | Request blocked (one pulse per blocked cycle) |
| vdd_en | output | NBANK | Supply switch enable per bank |
| vss_en | output | NBANK | Ground switch enable per bank |
| bank_rdy | output | NBANK | Bank accessible |
| bank_valid | output | NBANK | Bank contents still valid |
| bank_err | output | NBANK | Sticky access-violation flag per bank |

## Verification
The bench builds the block with eight banks and a 16-word bank span (BANK_AW=4), keeping the 10-cycle wake window. With that span, the whole 128-word address space can be swept for every bank in every one of the four codes. Each wake-up window is also walked cycle by cycle with requests that target the waking bank. Same-cycle clashes between software writes and violations, and zero writes to the status register, are driven explicitly. A cycle-level reference model then compares every output in every cycle.

// File: rtl/ram_pwr_ctl.sv
module ram_pwr_ctl #(
  parameter int NBANK    = 8,
  parameter int BANK_AW  = 12,
  parameter int WAKE_CYC = 10,
  localparam int REG_W  = 2 * NBANK,
  localparam int SEL_W  = $clog2(NBANK),
  localparam int ADDR_W = BANK_AW + SEL_W,
  localparam int CNT_W  = $clog2(WAKE_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              acc_req,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_gnt,
  output logic              acc_viol,
  output logic [NBANK-1:0]  vdd_en,
  output logic [NBANK-1:0]  vss_en,
  output logic [NBANK-1:0]  bank_rdy,
  output logic [NBANK-1:0]  bank_valid,
  output logic [NBANK-1:0]  bank_err
);

  logic [REG_W-1:0] mode_q, mode_d;
  logic [SEL_W-1:0] sel;
  logic [NBANK-1:0] hit;
  logic             stat_we;

  assign mode_d  = (reg_we && !reg_sel) ? reg_wdata : mode_q;
  assign stat_we = reg_we && reg_sel;
  assign sel     = acc_addr[ADDR_W-1:BANK_AW];
  assign hit     = acc_req ? (NBANK'(1) << sel) : '0;

  assign acc_gnt   = |(hit & bank_rdy);
  assign acc_viol  = |(hit & ~bank_rdy);
  assign reg_rdata = reg_sel ? {bank_valid, bank_err} : mode_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_q <= '1;
    else        mode_q <= mode_d;

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic [CNT_W-1:0] cnt;
    logic act_q, act_d, ret_q, bad, lose, val_q, err_q;

    assign act_q = &mode_q[2*i +: 2];
    assign act_d = &mode_d[2*i +: 2];
    assign ret_q = mode_q[2*i +: 2] == 2'b10;
    assign bad   = hit[i] & ~bank_rdy[i];
    assign lose  = (mode_q[2*i+1] && !mode_d[2*i+1]) || (bad && ret_q);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)              cnt <= '0;
      else if (act_d && !act_q) cnt <= CNT_W'(WAKE_CYC);
      else if (cnt != '0)       cnt <= cnt - 1'b1;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                  val_q <= 1'b1;
      else if (lose)                               val_q <= 1'b0;
      else if (stat_we && reg_wdata[NBANK+i])      val_q <= 1'b1;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                           err_q <= 1'b0;
      else if (bad)                         err_q <= 1'b1;
      else if (stat_we && reg_wdata[i])     err_q <= 1'b0;

    assign vdd_en[i]     = mode_q[2*i+1];
    assign vss_en[i]     = mode_q[2*i];
    assign bank_rdy[i]   = act_q && (cnt == '0);
    assign bank_valid[i] = val_q;
    assign bank_err[i]   = err_q;
  end

endmodule

// File: rtl/ram_pwr_ctl_chk.sv
module ram_pwr_ctl_chk #(
  parameter int NBANK   = 8,
  parameter int BANK_AW = 12,
  localparam int SEL_W  = $clog2(NBANK),
  localparam int ADDR_W = BANK_AW + SEL_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_req,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_gnt,
  input logic              acc_viol,
  input logic [NBANK-1:0]  vdd_en,
  input logic [NBANK-1:0]  vss_en,
  input logic [NBANK-1:0]  bank_rdy,
  input logic [NBANK-1:0]  bank_valid,
  input logic [NBANK-1:0]  bank_err
);

  logic [SEL_W-1:0] csel;
  assign csel = acc_addr[ADDR_W-1:BANK_AW];

  // R6
  gnt_viol_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_gnt && acc_viol));

  // R6
  req_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req == (acc_gnt || acc_viol));

  // R3
  rdy_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_rdy & ~(vdd_en & vss_en)) == '0);

  // R7
  viol_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_viol |=> bank_err[$past(csel)]);

  // R9
  ret_touch_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_viol && vdd_en[csel] && !vss_en[csel]) |=> !bank_valid[$past(csel)]);

  for (genvar i = 0; i < NBANK; i++) begin : g_chk
    // R4
    wake_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vdd_en[i] && vss_en[i]) |-> !bank_rdy[i]);

    // R8
    disable_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vdd_en[i]) |-> !bank_valid[i]);
  end

endmodule

bind ram_pwr_ctl ram_pwr_ctl_chk #(.NBANK(NBANK), .BANK_AW(BANK_AW)) chk_i (.*);

// File: tb/ram_pwr_ctl_tb_top.sv
module ram_pwr_ctl_tb_top;
  localparam int NB = 8;
  localparam int AW = 4;
  localparam int WK = 10;
  localparam int RW = 2 * NB;
  localparam int DW = AW + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0, reg_sel = 1'b0, acc_req = 1'b0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic [DW-1:0] acc_addr = '0;
  logic acc_gnt, acc_viol;
  logic [NB-1:0] vdd_en, vss_en, bank_rdy, bank_valid, bank_err;

  int nchk = 0, nerr = 0;

  logic [1:0] m_mode [NB];
  int         m_cnt  [NB];
  logic [NB-1:0] m_val, m_err;

  always #10 clk = ~clk;

  ram_pwr_ctl #(.NBANK(NB), .BANK_AW(AW), .WAKE_CYC(WK)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_req(acc_req),
    .acc_addr(acc_addr), .acc_gnt(acc_gnt), .acc_viol(acc_viol),
    .vdd_en(vdd_en), .vss_en(vss_en), .bank_rdy(bank_rdy),
    .bank_valid(bank_valid), .bank_err(bank_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic sl, input logic [RW-1:0] wd,
                      input logic rq, input logic [DW-1:0] ad);
    logic [NB-1:0] e_rdy, e_vdd, e_vss;
    logic [RW-1:0] e_mode;
    int tb;
    @(negedge clk);
    reg_we = we; reg_sel = sl; reg_wdata = wd; acc_req = rq; acc_addr = ad;
    #1;
    for (int b = 0; b < NB; b++) begin
      e_rdy[b] = (m_mode[b] == 2'b11) && (m_cnt[b] == 0);
      e_vdd[b] = m_mode[b][1];
      e_vss[b] = m_mode[b][0];
      e_mode[2*b +: 2] = m_mode[b];
    end
    tb = int'(ad[DW-1:AW]);
    chk("R2 supply vdd", 32'(vdd_en), 32'(e_vdd));
    chk("R2 supply vss", 32'(vss_en), 32'(e_vss));
    chk("R3 R4 R12 ready", 32'(bank_rdy), 32'(e_rdy));
    chk("R5 R6 grant", 32'(acc_gnt), 32'(rq && e_rdy[tb]));
    chk("R6 violation", 32'(acc_viol), 32'(rq && !e_rdy[tb]));
    chk("R7 R10 R12 error", 32'(bank_err), 32'(m_err));
    chk("R8 R9 R10 valid", 32'(bank_valid), 32'(m_val));
    chk("R11 readback", 32'(reg_rdata), sl ? 32'({m_val, m_err}) : 32'(e_mode));
    @(posedge clk);
    for (int b = 0; b < NB; b++) begin
      logic [1:0] old_m, new_m;
      logic bad;
      old_m = m_mode[b];
      new_m = (we && !sl) ? wd[2*b +: 2] : old_m;
      bad = rq && (tb == b) && !e_rdy[b];
      if (new_m == 2'b11 && old_m != 2'b11) m_cnt[b] = WK;
      else if (m_cnt[b] > 0) m_cnt[b]--;
      if ((old_m[1] && !new_m[1]) || (bad && old_m == 2'b10)) m_val[b] = 1'b0;
      else if (we && sl && wd[NB+b]) m_val[b] = 1'b1;
      if (bad) m_err[b] = 1'b1;
      else if (we && sl && wd[b]) m_err[b] = 1'b0;
      m_mode[b] = new_m;
    end
  endtask

  function automatic logic [RW-1:0] one_bank(input int b, input logic [1:0] m);
    logic [RW-1:0] v = '1;
    v[2*b +: 2] = m;
    return v;
  endfunction

  initial begin
    for (int b = 0; b < NB; b++) begin m_mode[b] = 2'b11; m_cnt[b] = 0; end
    m_val = '1; m_err = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset control", 32'(reg_rdata), 32'hFFFF);
    chk("R1 reset ready", 32'(bank_rdy), 32'hFF);
    chk("R1 reset valid", 32'(bank_valid), 32'hFF);
    chk("R1 reset error", 32'(bank_err), 32'h0);
    rst_n = 1'b1;

    // R5: every address with all banks active
    for (int a = 0; a < (1 << DW); a++) step(1'b0, a[0], '0, 1'b1, DW'(a));

    // every bank in every non-active code, full address sweep, then wake-up walk
    for (int b = 0; b < NB; b++) begin
      for (int k = 0; k < 3; k++) begin
        logic [1:0] m;
        m = (k == 0) ? 2'b10 : (k == 1) ? 2'b00 : 2'b01;
        step(1'b1, 1'b0, one_bank(b, m), 1'b0, '0);
        for (int a = 0; a < (1 << DW); a++) step(1'b0, a[0], '0, 1'b1, DW'(a));
        step(1'b1, 1'b1, RW'(0), 1'b0, '0);            // R10 zero write no effect
        step(1'b1, 1'b0, '1, 1'b0, '0);                 // R4 back to active
        for (int w = 0; w < WK + 2; w++) step(1'b0, w[0], '0, 1'b1, DW'(b << AW));
        step(1'b1, 1'b1, '1, 1'b0, '0);
      end
    end

    // R7 R10: same-cycle violation in retention with err clear and valid set
    step(1'b1, 1'b0, one_bank(2, 2'b10), 1'b0, '0);
    step(1'b1, 1'b1, '1, 1'b1, DW'(2 << AW));
    step(1'b0, 1'b1, '0, 1'b0, '0);
    // R9: retention without access keeps contents; wake violations keep valid
    step(1'b1, 1'b0, one_bank(5, 2'b10), 1'b0, '0);
    repeat (3) step(1'b0, 1'b1, '0, 1'b0, '0);
    step(1'b1, 1'b0, '1, 1'b0, '0);
    for (int w = 0; w < WK + 2; w++) step(1'b0, 1'b1, '0, 1'b1, DW'((5 << AW) + 15));
    // R4: rewriting active during the window does not restart it
    step(1'b1, 1'b0, one_bank(6, 2'b00), 1'b0, '0);
    step(1'b1, 1'b0, '1, 1'b0, '0);
    repeat (4) step(1'b0, 1'b0, '0, 1'b0, '0);
    step(1'b1, 1'b0, '1, 1'b0, '0);
    for (int w = 0; w < WK; w++) step(1'b0, 1'b1, '0, 1'b1, DW'(6 << AW));

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule